// File: doc/BRIEF.md
# Indexed Colour Palette Converter

This block turns framebuffer pixel words into 18-bit RGB for a display output. In indexed mode the low byte of each pixel picks one of 256 palette entries, and the stored entry is sent out. In direct mode a 16-bit pixel with 5, 6 and 5 bits per channel skips the palette and is widened to 6 bits per channel.

Software fills the palette through two registers. It first writes an entry number to a pointer register. Each write to the entry-data register then stores one colour and moves the pointer on. Reads of the entry-data register work the same way, so a run of entries can be read back in sequence. A single bit in a format register picks the mode. The RGB output is registered and appears one clock after the pixel is presented.

Top module: `pal_rgb_conv`

## Requirements
- R1: After reset, `rgb_out` is 0, the format register (offset 0x0C) reads 0, which selects direct mode, and the pointer register (offset 0x70) reads 0.
- R2: A write to offset 0x70 with a value below 256 loads the pointer. A read of 0x70 returns the pointer in bits 7:0, with all higher bits zero.
- R3: A write to offset 0x70 with a value of 256 or more is ignored, and the pointer keeps its previous value.
- R4: A write to offset 0x74 stores `bus_wdata[17:0]` in the entry selected by the pointer and ignores the upper data bits. The pointer then increments, and it wraps from 255 to 0.
- R5: While offset 0x74 is addressed, `bus_rdata` shows the entry at the pointer in bits 17:0, with upper bits zero. A read strobe at 0x74 increments the pointer in the same way as a write.
- R6: Format register bit 0 set to 1 selects indexed mode. The output is the palette entry selected by `pix_in[7:0]`, and `pix_in[15:8]` has no effect.
- R7: Format bit 0 cleared selects direct mode. The pixel fields are red at 15:11, green at 10:5 and blue at 4:0. The output fields are red at 17:12, green at 11:6 and blue at 5:0. Red and blue are widened by appending a copy of their most significant bit as a new least significant bit. Green passes through unchanged.
- R8: When `pix_valid` is low at a clock edge, `rgb_out` becomes 0 at that edge.
- R9: `rgb_out` changes only at the clock edge that samples the pixel, so the latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; at 0x74 it advances the pointer |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pix_in | input | 16 | Pixel word |
| pix_valid | input | 1 | Pixel strobe |
| rgb_out | output | 18 | Registered RGB, 6 bits per channel |

## Verification
The assertions assume that software raises at most one of `bus_wr` or `bus_rd` in a cycle, and never targets the pointer and the entry-data register in the same cycle. The bench meets this because each bus task raises exactly one strobe for one cycle. The pixel checks are made only while no palette write is in progress, so the question of which value a pixel reads when its entry is being written in the same cycle never comes up. All pixel patterns are driven at the falling edge and sampled one falling edge later, so exactly one rising edge lies between the two.

// File: rtl/pal_pkg.sv
package pal_pkg;

   typedef enum logic {
      FMT_DIRECT  = 1'b0,
      FMT_INDEXED = 1'b1
   } pix_fmt_e;

   localparam int unsigned OFS_FORMAT  = 32'h0C;
   localparam int unsigned OFS_POINTER = 32'h70;
   localparam int unsigned OFS_ENTRY   = 32'h74;

endpackage

// File: rtl/pal_store.sv
module pal_store #(
   parameter int IDX_W = 8,
   parameter int ENT_W = 18
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [ENT_W-1:0] wdata,
   input  logic [IDX_W-1:0] pix_idx,
   output logic [ENT_W-1:0] pix_ent,
   input  logic [IDX_W-1:0] sw_idx,
   output logic [ENT_W-1:0] sw_ent
);
   localparam int DEPTH = 1 << IDX_W;

   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign pix_ent = mem[pix_idx];
   assign sw_ent  = mem[sw_idx];
endmodule

// File: rtl/pal_regs.sv
module pal_regs
   import pal_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int ENT_W  = 18,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output pix_fmt_e          fmt,
   output logic [IDX_W-1:0]  ptr,
   output logic              ent_we,
   output logic [ENT_W-1:0]  ent_wdata,
   input  logic [ENT_W-1:0]  ent_rdata
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic hit_fmt, hit_ptr, hit_ent, ptr_load, ptr_step;
   logic [IDX_W-1:0] ptr_q;
   pix_fmt_e fmt_q;

   assign hit_fmt = (bus_addr == ADDR_W'(OFS_FORMAT));
   assign hit_ptr = (bus_addr == ADDR_W'(OFS_POINTER));
   assign hit_ent = (bus_addr == ADDR_W'(OFS_ENTRY));

   assign ptr_load = bus_wr && hit_ptr && (bus_wdata < DATA_W'(DEPTH));
   assign ptr_step = (bus_wr || bus_rd) && hit_ent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         fmt_q <= FMT_DIRECT;
      end else begin
         if (ptr_load) begin
            ptr_q <= bus_wdata[IDX_W-1:0];
         end else if (ptr_step) begin
            ptr_q <= ptr_q + 1'b1;
         end
         if (bus_wr && hit_fmt) begin
            fmt_q <= pix_fmt_e'(bus_wdata[0]);
         end
      end
   end

   assign ent_we    = bus_wr && hit_ent;
   assign ent_wdata = bus_wdata[ENT_W-1:0];
   assign ptr       = ptr_q;
   assign fmt       = fmt_q;

   always_comb begin
      bus_rdata = '0;
      if (hit_fmt) begin
         bus_rdata[0] = fmt_q;
      end else if (hit_ptr) begin
         bus_rdata[IDX_W-1:0] = ptr_q;
      end else if (hit_ent) begin
         bus_rdata[ENT_W-1:0] = ent_rdata;
      end
   end

   // R4: each entry write moves the pointer on by one, modulo the depth
   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_ent) |=> (ptr_q == $past(ptr_q) + 1'b1))
      else $error("pointer did not advance after entry write");

   // R3: an out-of-range pointer value leaves the pointer alone
   p_ptr_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_ptr && bus_wdata[DATA_W-1:IDX_W] != '0) |=> $stable(ptr_q))
      else $error("out-of-range pointer write took effect");

   // R6: the format only changes on a write to its register
   p_fmt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hit_fmt) |=> $stable(fmt_q))
      else $error("format changed without a write");
endmodule

// File: rtl/pal_widen.sv
module pal_widen #(
   parameter int CH_W     = 6,
   parameter bit FILL_MSB = 1'b1
) (
   input  logic [3*CH_W-3:0] pix,
   output logic [3*CH_W-1:0] rgb
);
   localparam int PIX_W = 3*CH_W - 2;
   localparam int NB_W  = CH_W - 1;

   logic [NB_W-1:0] r_n, b_n;
   logic [CH_W-1:0] g_n;

   assign r_n = pix[PIX_W-1 -: NB_W];
   assign g_n = pix[NB_W +: CH_W];
   assign b_n = pix[NB_W-1:0];

   generate
      if (FILL_MSB) begin : g_msb_fill
         assign rgb = {r_n, r_n[NB_W-1], g_n, b_n, b_n[NB_W-1]};
      end else begin : g_zero_fill
         assign rgb = {r_n, 1'b0, g_n, b_n, 1'b0};
      end
   endgenerate
endmodule

// File: rtl/pal_rgb_conv.sv
module pal_rgb_conv
   import pal_pkg::*;
#(
   parameter int CH_W     = 6,
   parameter int IDX_W    = 8,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit FILL_MSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [3*CH_W-3:0] pix_in,
   input  logic              pix_valid,
   output logic [3*CH_W-1:0] rgb_out
);
   localparam int PIX_W = 3*CH_W - 2;
   localparam int ENT_W = 3*CH_W;

   generate
      if (CH_W < 2) begin : g_bad_ch
         $error("CH_W must be at least 2");
      end
      if (IDX_W > PIX_W) begin : g_bad_idx
         $error("IDX_W must fit in the pixel word");
      end
      if (DATA_W <= IDX_W || DATA_W < ENT_W) begin : g_bad_data
         $error("DATA_W too narrow for pointer or entry");
      end
   endgenerate

   pix_fmt_e         fmt;
   logic [IDX_W-1:0] ptr;
   logic             ent_we;
   logic [ENT_W-1:0] ent_wdata, sw_ent, pal_ent, wide_rgb, rgb_d;

   pal_regs #(
      .IDX_W (IDX_W), .ENT_W (ENT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .fmt      (fmt),
      .ptr      (ptr),
      .ent_we   (ent_we),
      .ent_wdata(ent_wdata),
      .ent_rdata(sw_ent)
   );

   pal_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
      .clk    (clk),
      .we     (ent_we),
      .waddr  (ptr),
      .wdata  (ent_wdata),
      .pix_idx(pix_in[IDX_W-1:0]),
      .pix_ent(pal_ent),
      .sw_idx (ptr),
      .sw_ent (sw_ent)
   );

   pal_widen #(.CH_W(CH_W), .FILL_MSB(FILL_MSB)) u_widen (
      .pix(pix_in),
      .rgb(wide_rgb)
   );

   always_comb begin
      if (!pix_valid) begin
         rgb_d = '0;
      end else if (fmt == FMT_INDEXED) begin
         rgb_d = pal_ent;
      end else begin
         rgb_d = wide_rgb;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rgb_out <= '0;
      end else begin
         rgb_out <= rgb_d;
      end
   end

   // R8: an idle pixel slot gives black one cycle later
   p_idle_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> (rgb_out == '0))
      else $error("output not zero after idle slot");

   // R7: green field passes straight from pixel to output in direct mode
   p_green_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && fmt == FMT_DIRECT)
      |=> (rgb_out[CH_W +: CH_W] == $past(pix_in[CH_W-1 +: CH_W])))
      else $error("green mismatch in direct mode");

   generate
      if (FILL_MSB) begin : g_fill_chk
         // R7: widened red and blue repeat their top bit in the new low bit
         p_msb_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && fmt == FMT_DIRECT)
            |=> (rgb_out[2*CH_W] == rgb_out[ENT_W-1]
                 && rgb_out[0] == rgb_out[CH_W-1]))
            else $error("widened low bit differs from top bit");
      end
   endgenerate
endmodule

// File: tb/pal_rgb_conv_tb.sv
module pal_rgb_conv_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pix_in = '0;
   logic        pix_valid = 1'b0;
   logic [17:0] rgb_out;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [17:0] mdl [256];

   always #4 clk = ~clk;

   pal_rgb_conv u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pix_in(pix_in), .pix_valid(pix_valid), .rgb_out(rgb_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pixel(input logic v, input logic [15:0] p, output logic [17:0] q);
      @(negedge clk);
      pix_valid = v; pix_in = p;
      @(negedge clk);
      q = rgb_out;
   endtask

   function automatic logic [17:0] widen(input logic [15:0] p);
      return {p[15:11], p[15], p[10:5], p[4:0], p[4]};
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      check("R1 rgb after reset", 32'(rgb_out), 32'h0);
      bus_read(8'h0C, d);
      check("R1 format after reset", d, 32'h0);
      bus_read(8'h70, d);
      check("R1 pointer after reset", d, 32'h0);
   endtask

   task automatic t_pointer();
      logic [31:0] d;
      bus_write(8'h70, 32'd5);
      bus_read(8'h70, d);
      check("R2 pointer load", d, 32'd5);
      bus_write(8'h70, 32'd255);
      bus_read(8'h70, d);
      check("R2 pointer load top", d, 32'd255);
      bus_write(8'h70, 32'd256);
      bus_read(8'h70, d);
      check("R3 pointer write 256 ignored", d, 32'd255);
      bus_write(8'h70, 32'h8000_0003);
      bus_read(8'h70, d);
      check("R3 pointer write large ignored", d, 32'd255);
   endtask

   task automatic t_load();
      logic [31:0] d;
      bus_write(8'h70, 32'd250);
      for (int i = 0; i < 8; i++) begin
         logic [17:0] v;
         v = 18'h2A5A5 ^ 18'(i * 18'h01F3F);
         mdl[(250 + i) % 256] = v;
         bus_write(8'h74, 32'hFFFC_0000 | 32'(v));
      end
      bus_read(8'h70, d);
      check("R4 pointer wraps after writes", d, 32'd2);
      for (int i = 0; i < 16; i++) begin
         logic [17:0] v;
         v = 18'(i * 18'h1111 + 18'h00413);
         mdl[16 + i] = v;
      end
      bus_write(8'h70, 32'd16);
      for (int i = 0; i < 16; i++) bus_write(8'h74, 32'(mdl[16 + i]));
   endtask

   task automatic t_readback();
      logic [31:0] d;
      bus_write(8'h70, 32'd250);
      for (int i = 0; i < 8; i++) begin
         bus_read(8'h74, d);
         check("R5 entry readback", d, 32'(mdl[(250 + i) % 256]));
      end
      bus_read(8'h70, d);
      check("R5 pointer after reads", d, 32'd2);
   endtask

   task automatic t_indexed();
      logic [31:0] d;
      logic [17:0] q;
      bus_write(8'h0C, 32'h1);
      bus_read(8'h0C, d);
      check("R6 format reads indexed", d, 32'h1);
      for (int i = 0; i < 8; i++) begin
         logic [7:0] ix;
         ix = 8'(250 + i);
         pixel(1'b1, {8'(i * 37 + 1), ix}, q);
         check("R6 indexed pixel", 32'(q), 32'(mdl[ix]));
      end
      pixel(1'b1, 16'h0014, q);
      check("R6 indexed entry 20", 32'(q), 32'(mdl[20]));
      pixel(1'b1, 16'hC314, q);
      check("R6 upper byte ignored", 32'(q), 32'(mdl[20]));
   endtask

   task automatic t_direct();
      logic [17:0] q;
      logic [15:0] pats [6] = '{16'hFFFF, 16'h0000, 16'h8410, 16'h7BEF, 16'hF800, 16'h001F};
      bus_write(8'h0C, 32'h0);
      foreach (pats[i]) begin
         pixel(1'b1, pats[i], q);
         check("R7 direct widen", 32'(q), 32'(widen(pats[i])));
      end
      pixel(1'b1, 16'h07E0, q);
      check("R7 green only", 32'(q), 32'h00FC0);
   endtask

   task automatic t_valid();
      logic [17:0] q;
      pixel(1'b1, 16'hFFFF, q);
      check("R8 valid before idle", 32'(q), 32'h3FFFF);
      pixel(1'b0, 16'hFFFF, q);
      check("R8 idle gives zero", 32'(q), 32'h0);
      bus_write(8'h0C, 32'h1);
      pixel(1'b0, 16'h00FA, q);
      check("R8 idle zero indexed", 32'(q), 32'h0);
      bus_write(8'h0C, 32'h0);
   endtask

   task automatic t_latency();
      logic [17:0] q;
      pixel(1'b0, 16'h0, q);
      @(negedge clk);
      pix_valid = 1'b1; pix_in = 16'h8410;
      #2;
      check("R9 no change before edge", 32'(rgb_out), 32'h0);
      @(negedge clk);
      check("R9 value after one edge", 32'(rgb_out), 32'(widen(16'h8410)));
      pix_valid = 1'b0;
      #2;
      check("R9 held until next edge", 32'(rgb_out), 32'(widen(16'h8410)));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pointer();
      t_load();
      t_readback();
      t_indexed();
      t_direct();
      t_valid();
      t_latency();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule